// File: doc/BRIEF.md
# Kill-Qualified System Bus Responder

This block sits on the memory side of a single-master 32-bit system bus and answers the master's transfer requests from a small internal word memory. The master opens a cycle by pulling an active-low start strobe low. It can cancel that same cycle by also pulling an active-low kill strobe low late in the cycle. The responder treats the cycle as a real transfer only when the start strobe is low and the kill strobe is high. A cancelled cycle leaves no trace: no acknowledge, no memory update.

An accepted transfer is either a single transfer of 8, 16 or 32 bits or a four-beat line transfer of 128 bits. Each beat is acknowledged with a one-cycle low pulse on an active-low acknowledge. Beats are back to back, and the first one comes in the cycle after the start cycle. Read data is presented only while the responder raises the read-data enable that tells the master to capture it. Write data is taken from the master in each acknowledged beat.

Top module: `xfer_responder`

## Requirements
- R1: A cycle with the start strobe low and the kill strobe high, seen while no transfer is in progress, starts a transfer. Its first acknowledge (ack_n low) appears in the next cycle.
- R2: A cycle with both the start strobe and the kill strobe low is a no-operation. It produces no acknowledge, and its write data never reaches the memory.
- R3: While idle, a cycle with the start strobe high is a no-operation at any level of the kill strobe. The kill strobe toggling alone never causes an acknowledge.
- R4: The direction input chooses the transfer type: 1 means read and 0 means write. A write stores the wdata present in each acknowledged beat.
- R5: Size codes are 2'b00 for 32-bit, 2'b01 for 8-bit, 2'b10 for 16-bit and 2'b11 for a line. Byte lanes are big-endian. Byte offset 0 is on bits [31:24] and offset 3 is on bits [7:0]. A halfword with addr[1]=0 is on [31:16], and with addr[1]=1 it is on [15:0]. A write changes only the addressed lanes. A read returns the addressed lanes in place and zero in all other lanes.
- R6: A line transfer gives exactly four consecutive acknowledge pulses. The word address starts at addr[3:2] and steps by one word modulo 16 bytes, within the aligned 16-byte block.
- R7: rd_en is high exactly in the acknowledged beats of a read. rdata is zero whenever rd_en is low.
- R8: Start strobes that arrive while a transfer is in progress are ignored. They neither lengthen nor restart it.
- R9: While rst_n is low, ack_n is high and rd_en is low. The transfer in progress is dropped, and every memory word reads back as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low transfer start strobe |
| kill_n | input | 1 | Active-low late cancel for the start cycle |
| rd_nwr | input | 1 | Direction, 1 = read, 0 = write |
| size | input | 2 | Transfer size code (see R5) |
| addr | input | ADDR_W | Byte address, sampled in the start cycle |
| wdata | input | DATA_W | Write data, sampled in each acknowledged write beat |
| ack_n | output | 1 | Active-low per-beat acknowledge |
| rd_en | output | 1 | High while rdata carries valid read data |
| rdata | output | DATA_W | Read data, lane-masked, zero when not valid |

## Verification
The assertions assume the strobes and direction inputs hold known levels at every clock edge. They also assume the master keeps size and address meaningful only in the start cycle, while write data is meaningful in the beats. The bench drives every input to a defined value on the falling edge, so each cycle presents a clean, settled combination to the rising edge. Start strobes raised during a running transfer are deliberate stimulus. The properties are therefore stated only for cycles in which the responder is idle.

// File: rtl/xfer_responder_pkg.sv
package xfer_responder_pkg;

   typedef enum logic [1:0] {
      SZ_WORD = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_HALF = 2'b10,
      SZ_LINE = 2'b11
   } xfer_size_e;

   // Lane enable, bit i covers data bits [8i+7:8i]; byte offset 0 is lane 3.
   function automatic logic [3:0] lane_mask(input xfer_size_e sz, input logic [1:0] off);
      logic [3:0] m;
      unique case (sz)
         SZ_BYTE: m = 4'b1000 >> off;
         SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/resp_sequencer.sv
module resp_sequencer
   import xfer_responder_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_n,
   input  logic             kill_n,
   input  logic             rd_nwr,
   input  xfer_size_e       size,
   input  logic [IDX_W-1:0] addr_idx,
   input  logic [1:0]       addr_off,
   output logic             busy,
   output logic             is_rd,
   output logic [IDX_W-1:0] cur_idx,
   output xfer_size_e       cur_size,
   output logic [1:0]       cur_off
);

   localparam int LINE_BEATS = 4;
   localparam logic [1:0] LAST_LEFT = 2'(LINE_BEATS - 1);
   localparam logic [IDX_W-1:0] WRAP_MSK = IDX_W'(LINE_BEATS - 1);

   logic [1:0] beats_left;
   logic       accept;

   assign accept = !busy && !start_n && kill_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         beats_left <= '0;
         is_rd      <= 1'b0;
         cur_idx    <= '0;
         cur_size   <= SZ_WORD;
         cur_off    <= '0;
      end else if (accept) begin
         busy       <= 1'b1;
         beats_left <= (size == SZ_LINE) ? LAST_LEFT : 2'd0;
         is_rd      <= rd_nwr;
         cur_idx    <= addr_idx;
         cur_size   <= size;
         cur_off    <= addr_off;
      end else if (busy) begin
         if (beats_left == 2'd0) begin
            busy <= 1'b0;
         end else begin
            beats_left <= beats_left - 2'd1;
            cur_idx    <= (cur_idx & ~WRAP_MSK) | ((cur_idx + IDX_W'(1)) & WRAP_MSK);
         end
      end
   end

endmodule

// File: rtl/resp_lane_ctl.sv
module resp_lane_ctl
   import xfer_responder_pkg::*;
#(
   parameter int LANES = 4
) (
   input  xfer_size_e       size,
   input  logic [1:0]       off,
   output logic [LANES-1:0] be
);

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("resp_lane_ctl: lane mapping is defined for four byte lanes");
      end
   endgenerate

   always_comb be = lane_mask(size, off);

endmodule

// File: rtl/resp_regfile.sv
module resp_regfile #(
   parameter int DEPTH = 16,
   parameter int LANES = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int DATA_W = LANES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [LANES-1:0]  be,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [7:0] lane_mem [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int w = 0; w < DEPTH; w++) lane_mem[w] <= '0;
            end else if (we && be[g]) begin
               lane_mem[idx] <= wdata[g*8 +: 8];
            end
         end

         assign rdata[g*8 +: 8] = lane_mem[idx];
      end
   endgenerate

endmodule

// File: rtl/xfer_responder.sv
module xfer_responder
   import xfer_responder_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              kill_n,
   input  logic              rd_nwr,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack_n,
   output logic              rd_en,
   output logic [DATA_W-1:0] rdata
);

   localparam int IDX_W = $clog2(DEPTH);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("xfer_responder: data path must be 32 bits");
      end
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("xfer_responder: DEPTH must be a power of two of at least 4");
      end
      if (ADDR_W != IDX_W + 2) begin : g_bad_addr
         $error("xfer_responder: ADDR_W must equal log2(DEPTH)+2");
      end
   endgenerate

   logic             seq_busy;
   logic             seq_rd;
   logic [IDX_W-1:0] seq_idx;
   xfer_size_e       seq_size;
   logic [1:0]       seq_off;
   logic [LANES-1:0] lane_be;
   logic [DATA_W-1:0] mem_rdata;
   logic             mem_we;

   resp_sequencer #(.IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_n  (start_n),
      .kill_n   (kill_n),
      .rd_nwr   (rd_nwr),
      .size     (xfer_size_e'(size)),
      .addr_idx (addr[ADDR_W-1:2]),
      .addr_off (addr[1:0]),
      .busy     (seq_busy),
      .is_rd    (seq_rd),
      .cur_idx  (seq_idx),
      .cur_size (seq_size),
      .cur_off  (seq_off)
   );

   resp_lane_ctl #(.LANES(LANES)) u_lane (
      .size (seq_size),
      .off  (seq_off),
      .be   (lane_be)
   );

   assign mem_we = seq_busy && !seq_rd;

   resp_regfile #(.DEPTH(DEPTH), .LANES(LANES)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .be    (lane_be),
      .idx   (seq_idx),
      .wdata (wdata),
      .rdata (mem_rdata)
   );

   assign ack_n = !seq_busy;
   assign rd_en = seq_busy && seq_rd;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_rlane
         assign rdata[g*8 +: 8] = (rd_en && lane_be[g]) ? mem_rdata[g*8 +: 8] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/xfer_responder_chk.sv
module xfer_responder_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_n,
   input logic              kill_n,
   input logic              busy,
   input logic              ack_n,
   input logic              rd_en,
   input logic [DATA_W-1:0] rdata
);

   logic [2:0] ack_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ack_run <= '0;
      else if (ack_n)       ack_run <= '0;
      else if (ack_run != 3'd7) ack_run <= ack_run + 3'd1;
   end

   AST_ACCEPT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_n && kill_n) |=> !ack_n);                   // R1
   AST_KILLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start_n && !kill_n) |=> ack_n);                   // R2
   AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_n) |=> ack_n);                               // R3
   AST_RDEN_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !ack_n);                                           // R7
   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));                                   // R7
   AST_LINE_MAX_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_run <= 3'd4);                                            // R6

endmodule

bind xfer_responder xfer_responder_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_n (start_n),
   .kill_n  (kill_n),
   .busy    (seq_busy),
   .ack_n   (ack_n),
   .rd_en   (rd_en),
   .rdata   (rdata)
);

// File: tb/xfer_responder_bench.sv
module xfer_responder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_n = 1'b1;
   logic        kill_n = 1'b1;
   logic        rd_nwr = 1'b1;
   logic [1:0]  size = 2'b00;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        ack_n;
   logic        rd_en;
   logic [31:0] rdata;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] mmem [16];
   bit          mbusy = 0;
   int          mleft = 0;
   int          midx = 0;
   logic [1:0]  msz = 0;
   logic [1:0]  moff = 0;
   bit          mrd = 0;

   always #2 clk = ~clk;

   xfer_responder u_xfer_responder (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .kill_n(kill_n),
      .rd_nwr(rd_nwr), .size(size), .addr(addr), .wdata(wdata),
      .ack_n(ack_n), .rd_en(rd_en), .rdata(rdata)
   );

   function automatic bit lane_on(input logic [1:0] sz, input logic [1:0] off, input int lane);
      int boff = 3 - lane;
      if (sz == 2'b01) return boff == int'(off);
      if (sz == 2'b10) return (boff / 2) == int'(off[1]);
      return 1'b1;
   endfunction

   function automatic logic [31:0] expected_rdata();
      logic [31:0] r = '0;
      if (!(mbusy && mrd)) return r;
      for (int l = 0; l < 4; l++)
         if (lane_on(msz, moff, l)) r[l*8 +: 8] = mmem[midx][l*8 +: 8];
      return r;
   endfunction

   task automatic compare(input string tag);
      logic [33:0] act, exp;
      act = {ack_n, rd_en, rdata};
      exp = {!mbusy, mbusy && mrd, expected_rdata()};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {ack_n,rd_en,rdata} actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      mbusy = 0;
      for (int w = 0; w < 16; w++) mmem[w] = '0;
   endtask

   task automatic cyc(input bit s_n, input bit k_n, input bit rd, input logic [1:0] sz,
                      input logic [5:0] a, input logic [31:0] wd, input string tag);
      @(negedge clk);
      start_n = s_n; kill_n = k_n; rd_nwr = rd; size = sz; addr = a; wdata = wd;
      @(posedge clk);
      if (mbusy) begin
         if (!mrd)
            for (int l = 0; l < 4; l++)
               if (lane_on(msz, moff, l)) mmem[midx][l*8 +: 8] = wd[l*8 +: 8];
         if (mleft == 0) mbusy = 0;
         else begin
            mleft--;
            midx = (midx & ~3) | ((midx + 1) & 3);
         end
      end else if (!s_n && k_n) begin
         mbusy = 1; mleft = (sz == 2'b11) ? 3 : 0;
         midx = int'(a[5:2]); moff = a[1:0]; msz = sz; mrd = rd;
      end
      #1;
      compare(tag);
   endtask

   task automatic idle(input string tag);
      cyc(1, 1, 1, 2'b00, 6'h00, 32'h0BAD_F00D, tag);
   endtask

   task automatic wr1(input logic [1:0] sz, input logic [5:0] a, input logic [31:0] d, input string tag);
      cyc(0, 1, 0, sz, a, 32'h0BAD_F00D, tag);
      cyc(1, 1, 1, 2'b00, 6'h00, d, tag);
   endtask

   task automatic rd1(input logic [1:0] sz, input logic [5:0] a, input string tag);
      cyc(0, 1, 1, sz, a, 32'h0, tag);
      cyc(1, 1, 1, 2'b00, 6'h00, 32'h0, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (2) @(negedge clk);
      #1 compare("R9 outputs in reset");
      @(negedge clk) rst_n = 1'b1;

      // R3: idle cycles, kill toggling without start
      cyc(1, 0, 1, 2'b00, 6'h04, 32'h0, "R3 kill alone");
      cyc(1, 1, 0, 2'b11, 6'h08, 32'h0, "R3 start high");
      cyc(1, 0, 0, 2'b00, 6'h0C, 32'h0, "R3 kill alone write");

      // R1, R4: word write then read
      wr1(2'b00, 6'h04, 32'hDEAD_BEEF, "R1 word write");
      rd1(2'b00, 6'h04, "R4 word read");

      // R2: killed write leaves memory unchanged
      cyc(0, 0, 0, 2'b00, 6'h04, 32'h0, "R2 killed start");
      cyc(1, 1, 0, 2'b00, 6'h00, 32'h1234_5678, "R2 no ack after kill");
      rd1(2'b00, 6'h04, "R2 memory untouched");

      // R5: byte lanes, big-endian
      wr1(2'b01, 6'h08, 32'h1111_1111, "R5 byte off0");
      wr1(2'b01, 6'h09, 32'h2222_2222, "R5 byte off1");
      wr1(2'b01, 6'h0A, 32'h3333_3333, "R5 byte off2");
      wr1(2'b01, 6'h0B, 32'h4444_4444, "R5 byte off3");
      rd1(2'b00, 6'h08, "R5 word after bytes");
      for (int o = 0; o < 4; o++) rd1(2'b01, 6'(8 + o), "R5 byte read");
      wr1(2'b10, 6'h0E, 32'hAAAA_BBBB, "R5 half low write");
      rd1(2'b10, 6'h0C, "R5 half high read");
      rd1(2'b10, 6'h0E, "R5 half low read");

      // R6: line write from word 7 wraps 7,4,5,6
      cyc(0, 1, 0, 2'b11, 6'h1C, 32'h0, "R6 line write start");
      for (int b = 0; b < 4; b++) cyc(1, 1, 1, 2'b00, 6'h00, 32'hC0DE_0000 + b, "R6 line write beat");
      idle("R6 line ends after four beats");
      // R6, R8: line read from word 5, start strobes during beats ignored
      cyc(0, 1, 1, 2'b11, 6'h14, 32'h0, "R6 line read start");
      for (int b = 0; b < 4; b++) cyc(0, 1, 0, 2'b00, 6'h04, 32'hFFFF_FFFF, "R8 start during beats");
      // start seen in last beat cycle was ignored: idle next
      idle("R8 no restart");
      // back-to-back transfers
      rd1(2'b00, 6'h10, "R7 read back to back");
      rd1(2'b00, 6'h18, "R7 second read");

      // R9: reset mid-transfer clears state and memory
      cyc(0, 1, 1, 2'b11, 6'h10, 32'h0, "R9 line before reset");
      cyc(1, 1, 1, 2'b00, 6'h00, 32'h0, "R9 beat before reset");
      @(negedge clk);
      rst_n = 1'b0;
      model_clear();
      #1 compare("R9 async reset drops transfer");
      @(negedge clk) rst_n = 1'b1;
      idle("R9 idle after reset");
      rd1(2'b00, 6'h04, "R9 memory cleared");
      rd1(2'b00, 6'h3C, "R9 unwritten word");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule